// File: doc/BRIEF.md
# Multichannel Delta-Sigma ADC Scan Sequencer

This block is the host-side controller for a 24-bit delta-sigma converter with eight analog inputs that is reached over a four-wire serial link. While `enable` is high it runs a scan session. The session opens with a one-time write of four setup registers. It then loops over scan steps. Each step selects one channel, converts it, reads it and presents the result. The block drives chip select, the serial clock and the outbound data line, and it samples the inbound data line.

There are two ways to pair the inputs. In single-ended mode each of the eight inputs is measured against the common input, so there are eight channels. In differential mode adjacent inputs form four pairs, with the even input positive and the odd input negative. The mode is captured when a session starts.

Each scan step does the following:
- it rewrites the input-multiplexer register;
- it issues the synchronise, wake-up and read-data commands;
- it waits for the converter's active-low data-ready line;
- it lets a settling gap pass;
- it clocks in three bytes and outputs them with the channel index.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset and whenever no session is active, `cs_n` is 1, `sclk` is 0 and `result_valid` is 0. `sclk` never pulses while `cs_n` is 1.
- R2: Bytes go out MSB first. `mosi` changes only in the cycle where `sclk` rises, and `miso` is captured where `sclk` falls. Each serial-clock half period lasts HALF_CLKS system clocks.
- R3: A session begins when `enable` is seen high in idle. It first sends 12 bytes, each register write being (0x50 | address), 0x00, value. The writes go to the status register (address 0, STATUS_VAL), control (address 2, CTRL_VAL), rate (address 3, RATE_VAL) and I/O (address 4, IO_VAL), in that order.
- R4: Every scan step sends 0x51, 0x00, the multiplexer code, then 0xFC, 0x00 and 0x01. After the wait and the settling gap it sends three 0x00 bytes while reading.
- R5: In single-ended mode the multiplexer code for channel n is {n, 4'h8}, which selects input n against common.
- R6: In differential mode the multiplexer code for pair k is {2k, 2k+1}, written as upper nibble and lower nibble.
- R7: After the 0x01 byte the block produces no serial clock until `drdy_n` is seen low.
- R8: The first read clock rises at least SETTLE_SCLK*2*HALF_CLKS system clocks after `drdy_n` is seen low.
- R9: The 24 bits read MSB first appear on `result` with the step's channel on `result_ch`. `result_valid` is a single-cycle pulse.
- R10: Channels advance by one per step, starting at 0 in each session. They wrap after 7 in single-ended mode and after 3 in differential mode.
- R11: `cs_n` stays 0 from the first setup byte through the last step. The setup writes are sent only once per session.
- R12: If `enable` is low when a result is presented, the session ends. `cs_n` goes to 1 and no further serial clock follows. A change of `diff_mode` during a session has no effect until the next session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Start a session, and keep scanning while high |
| diff_mode | input | 1 | 1 = four differential pairs, 0 = eight single-ended channels |
| drdy_n | input | 1 | Converter data-ready, active low |
| miso | input | 1 | Serial data from converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to converter |
| result | output | 24 | Last conversion result |
| result_ch | output | 3 | Channel or pair index of `result` |
| result_valid | output | 1 | One-cycle strobe for `result` |

## Verification
Some rules are checked by assertions on every cycle:
- the serial clock is quiet while chip select is high, and no clock runs while data-ready is awaited;
- `mosi` moves only on a rising serial clock, and a byte is launched only into a free shifter;
- the result strobe lasts one cycle, and differential indices stay below four.

Other behaviour can only be shown by the bench scenarios, which decode the byte stream and supply the converter's replies:
- the exact setup and per-step byte streams, including the multiplexer codes;
- the settling gap, the channel wrap in both modes and the restart at channel 0;
- that a mid-session mode change is ignored, and that the session ends cleanly.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_STEP, S_WAIT, S_SETTLE, S_READ, S_EMIT
    } seq_st_e;

    localparam logic [3:0] WR_OP      = 4'h5;
    localparam logic [3:0] ADDR_STAT  = 4'h0;
    localparam logic [3:0] ADDR_MUX   = 4'h1;
    localparam logic [3:0] ADDR_CTRL  = 4'h2;
    localparam logic [3:0] ADDR_RATE  = 4'h3;
    localparam logic [3:0] ADDR_IO    = 4'h4;
    localparam logic [7:0] CMD_SYNC   = 8'hFC;
    localparam logic [7:0] CMD_WAKE   = 8'h00;
    localparam logic [7:0] CMD_RDATA  = 8'h01;
    localparam int         SETUP_LEN  = 12;
    localparam int         STEP_LEN   = 6;
    localparam int         READ_LEN   = 3;

    // byte idx of the one-time setup stream: three bytes per register
    function automatic logic [7:0] setup_byte(input logic [3:0] idx,
                                              input logic [7:0] v_stat,
                                              input logic [7:0] v_ctrl,
                                              input logic [7:0] v_rate,
                                              input logic [7:0] v_io);
        logic [3:0] addr;
        logic [7:0] val;
        logic [3:0] grp;
        logic [3:0] pos;
        grp = idx / 4'd3;
        pos = idx % 4'd3;
        case (grp)
            4'd0:    begin addr = ADDR_STAT; val = v_stat; end
            4'd1:    begin addr = ADDR_CTRL; val = v_ctrl; end
            4'd2:    begin addr = ADDR_RATE; val = v_rate; end
            default: begin addr = ADDR_IO;   val = v_io;   end
        endcase
        case (pos)
            4'd0:    return {WR_OP, addr};
            4'd1:    return 8'h00;
            default: return val;
        endcase
    endfunction

endpackage

// File: rtl/adc_mux_code.sv
module adc_mux_code #(
    parameter int         CH_W       = 3,
    parameter logic [3:0] COMMON_SEL = 4'h8
) (
    input  logic [CH_W-1:0] ch,
    input  logic            diff,
    output logic [7:0]      code
);
    localparam int PAIR_W = CH_W - 1;

    logic [3:0] pos_sel;
    logic [3:0] neg_sel;

    always_comb begin
        pos_sel = 4'd0;
        neg_sel = 4'd0;
        if (diff) begin
            pos_sel = 4'({ch[PAIR_W-1:0], 1'b0});
            neg_sel = 4'({ch[PAIR_W-1:0], 1'b1});
        end else begin
            pos_sel = 4'(ch);
            neg_sel = COMMON_SEL;
        end
        code = {pos_sel, neg_sel};
    end
endmodule

// File: rtl/adc_spi_byte.sv
module adc_spi_byte #(
    parameter int HALF_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(HALF_CLKS - 1);

    typedef struct packed {
        logic          busy;
        logic [2:0]    bitn;
        logic [CW-1:0] cnt;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          sclk;
        logic          mosi;
        logic          done;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (go) begin
                d.busy = 1'b1;
                d.bitn = 3'd0;
                d.cnt  = '0;
                d.sh   = tx;
                d.sclk = 1'b1;
                d.mosi = tx[7];
            end
        end else if (q.cnt == CNT_END) begin
            d.cnt = '0;
            if (q.sclk) begin
                d.sclk = 1'b0;
                d.rx   = {q.rx[6:0], miso};
            end else if (q.bitn == 3'd7) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.bitn = q.bitn + 3'd1;
                d.sh   = {q.sh[6:0], 1'b0};
                d.sclk = 1'b1;
                d.mosi = q.sh[6];
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign rx   = q.rx;
    assign sclk = q.sclk;
    assign mosi = q.mosi;

    p_mosi_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mosi) |-> $rose(q.sclk));
    p_go_when_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !q.busy);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int         HALF_CLKS   = 2,
    parameter int         SETTLE_SCLK = 7,
    parameter logic [7:0] STATUS_VAL  = 8'h01,
    parameter logic [7:0] CTRL_VAL    = 8'h20,
    parameter logic [7:0] RATE_VAL    = 8'hF0,
    parameter logic [7:0] IO_VAL      = 8'hE0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        diff_mode,
    input  logic        drdy_n,
    input  logic        miso,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi,
    output logic [23:0] result,
    output logic [2:0]  result_ch,
    output logic        result_valid
);
    localparam int SETTLE_CLKS = SETTLE_SCLK * 2 * HALF_CLKS;
    localparam int SW          = $clog2(SETTLE_CLKS + 1);
    localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_CLKS - 1);
    localparam logic [3:0] SETUP_LAST = 4'(SETUP_LEN - 1);
    localparam logic [3:0] STEP_LAST  = 4'(STEP_LEN - 1);
    localparam logic [3:0] READ_LAST  = 4'(READ_LEN - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [3:0]    idx;
        logic [2:0]    ch;
        logic          diff;
        logic          cs_n;
        logic          go;
        logic          inflight;
        logic [7:0]    tx;
        logic [23:0]   data;
        logic [SW-1:0] wcnt;
        logic          valid;
    } seq_t;

    seq_t d, q;

    logic       spi_busy;
    logic       spi_done;
    logic [7:0] spi_rx;
    logic [7:0] mux_code;
    logic [7:0] step_tx;

    adc_mux_code #(.CH_W(3), .COMMON_SEL(4'h8)) mux_i (
        .ch   (q.ch),
        .diff (q.diff),
        .code (mux_code)
    );

    adc_spi_byte #(.HALF_CLKS(HALF_CLKS)) spi_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.go),
        .tx    (q.tx),
        .miso  (miso),
        .busy  (spi_busy),
        .done  (spi_done),
        .rx    (spi_rx),
        .sclk  (sclk),
        .mosi  (mosi)
    );

    always_comb begin
        case (q.idx)
            4'd0:    step_tx = {WR_OP, ADDR_MUX};
            4'd1:    step_tx = 8'h00;
            4'd2:    step_tx = mux_code;
            4'd3:    step_tx = CMD_SYNC;
            4'd4:    step_tx = CMD_WAKE;
            default: step_tx = CMD_RDATA;
        endcase
    end

    always_comb begin
        d       = q;
        d.go    = 1'b0;
        d.valid = 1'b0;
        case (q.st)
            S_IDLE: begin
                d.cs_n = 1'b1;
                if (enable) begin
                    d.st   = S_SETUP;
                    d.cs_n = 1'b0;
                    d.idx  = '0;
                    d.ch   = '0;
                    d.diff = diff_mode;
                end
            end
            S_SETUP: begin
                if (spi_done) begin
                    d.inflight = 1'b0;
                    if (q.idx == SETUP_LAST) begin
                        d.st  = S_STEP;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 4'd1;
                    end
                end else if (!q.inflight) begin
                    d.go       = 1'b1;
                    d.inflight = 1'b1;
                    d.tx       = setup_byte(q.idx, STATUS_VAL, CTRL_VAL, RATE_VAL, IO_VAL);
                end
            end
            S_STEP: begin
                if (spi_done) begin
                    d.inflight = 1'b0;
                    if (q.idx == STEP_LAST) begin
                        d.st = S_WAIT;
                    end else begin
                        d.idx = q.idx + 4'd1;
                    end
                end else if (!q.inflight) begin
                    d.go       = 1'b1;
                    d.inflight = 1'b1;
                    d.tx       = step_tx;
                end
            end
            S_WAIT: begin
                if (!drdy_n) begin
                    d.st   = S_SETTLE;
                    d.wcnt = '0;
                end
            end
            S_SETTLE: begin
                if (q.wcnt == SETTLE_END) begin
                    d.st  = S_READ;
                    d.idx = '0;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            S_READ: begin
                if (spi_done) begin
                    d.inflight = 1'b0;
                    d.data     = {q.data[15:0], spi_rx};
                    if (q.idx == READ_LAST) begin
                        d.st    = S_EMIT;
                        d.valid = 1'b1;
                    end else begin
                        d.idx = q.idx + 4'd1;
                    end
                end else if (!q.inflight) begin
                    d.go       = 1'b1;
                    d.inflight = 1'b1;
                    d.tx       = 8'h00;
                end
            end
            S_EMIT: begin
                d.ch  = (q.ch == (q.diff ? 3'd3 : 3'd7)) ? 3'd0 : q.ch + 3'd1;
                d.idx = '0;
                if (enable) begin
                    d.st = S_STEP;
                end else begin
                    d.st   = S_IDLE;
                    d.cs_n = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n         = q.cs_n;
    assign result       = q.data;
    assign result_ch    = q.ch;
    assign result_valid = q.valid;

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    p_cs_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_busy |-> !cs_n);
    p_no_clk_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT) |-> !spi_busy);
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    p_pair_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && q.diff) |-> (result_ch <= 3'd3));
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
    localparam int HALF   = 2;
    localparam int SETTLE = 7;
    localparam int SCLKS  = SETTLE * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        diff_mode = 1'b0;
    logic        drdy_n = 1'b1;
    logic        miso = 1'b0;
    logic        cs_n, sclk, mosi, result_valid;
    logic [23:0] result;
    logic [2:0]  result_ch;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int sclk_rises = 0;
    int nres = 0;
    bit finished = 0;

    // model state
    int          pos = 0;
    int          bits = 0;
    bit          m_diff = 0;
    logic [7:0]  shreg = 8'h00;
    bit          rd_req = 0;
    logic [2:0]  rd_ch = 3'd0;
    logic [26:0] expq[$];

    always #10 clk = ~clk;

    adc_scan_seq #(.HALF_CLKS(HALF), .SETTLE_SCLK(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .diff_mode(diff_mode),
        .drdy_n(drdy_n), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .result(result), .result_ch(result_ch), .result_valid(result_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int p, input bit dm);
        logic [7:0] vals[4];
        logic [3:0] adrs[4];
        int j, s, nch, ch;
        vals = '{8'h01, 8'h20, 8'hF0, 8'hE0};
        adrs = '{4'h0, 4'h2, 4'h3, 4'h4};
        if (p < 12) begin
            case (p % 3)
                0: return {4'h5, adrs[p/3]};
                1: return 8'h00;
                default: return vals[p/3];
            endcase
        end
        j = (p - 12) % 9;
        s = (p - 12) / 9;
        nch = dm ? 4 : 8;
        ch = s % nch;
        case (j)
            0: return 8'h51;
            2: return dm ? {4'(2*ch), 4'(2*ch+1)} : {4'(ch), 4'h8};
            3: return 8'hFC;
            5: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [23:0] word_for(input int n);
        case (n % 4)
            0: return 24'h800000 ^ 24'(n);
            1: return 24'h7FFFFF;
            2: return 24'hA5C35A + 24'(n) * 24'h010203;
            default: return 24'h000001 << (n % 24);
        endcase
    endfunction

    always @(posedge clk) cyc++;
    always @(posedge sclk) sclk_rises++;

    always @(negedge cs_n) begin
        pos = 0;
        bits = 0;
        m_diff = diff_mode;
    end

    // converter-side byte decoder: samples MOSI on the falling serial edge
    always @(negedge sclk) begin
        if (!cs_n) begin
            shreg = {shreg[6:0], mosi};
            bits++;
            if (bits == 8) begin
                logic [7:0] e;
                int j;
                bits = 0;
                e = exp_byte(pos, m_diff);
                j = (pos - 12) % 9;
                if (pos < 12)
                    chk(shreg == e, "R2 R3 setup byte", {24'h0, shreg}, {24'h0, e});
                else if (j == 2)
                    chk(shreg == e, m_diff ? "R6 mux code" : "R5 mux code", {24'h0, shreg}, {24'h0, e});
                else
                    chk(shreg == e, "R4 R11 step byte", {24'h0, shreg}, {24'h0, e});
                if (pos >= 12 && j == 5) begin
                    rd_ch = 3'(((pos - 12) / 9) % (m_diff ? 4 : 8));
                    rd_req = 1;
                end
                pos++;
            end
        end
    end

    // converter-side reply: data-ready, then result bits on MISO
    initial begin
        forever begin
            logic [23:0] w;
            int t0;
            wait (rd_req);
            rd_req = 0;
            repeat (5) @(negedge clk);
            w = word_for(nres);
            nres++;
            expq.push_back({rd_ch, w});
            drdy_n = 1'b0;
            t0 = cyc;
            for (int b = 23; b >= 0; b--) begin
                @(posedge sclk);
                if (b == 23)
                    chk(cyc - t0 >= SCLKS, "R7 R8 settle gap", 32'(cyc - t0), 32'(SCLKS));
                #1 miso = w[b];
            end
            @(negedge sclk);
            drdy_n = 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sclk) chk(0, "R1 clock while deselected", 32'(sclk), 32'd0);
            if (result_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R9 unexpected result", {8'h0, result}, 32'h0);
                end else begin
                    logic [26:0] e;
                    e = expq.pop_front();
                    chk(result == e[23:0], "R9 result data", {8'h0, result}, {8'h0, e[23:0]});
                    chk(result_ch == e[26:24], "R10 channel tag", {29'h0, result_ch}, {29'h0, e[26:24]});
                end
            end
        end
    end

    task automatic session(input bit dm, input int n, input bit flip);
        int cnt;
        int e0;
        diff_mode = dm;
        @(negedge clk);
        enable = 1'b1;
        cnt = 0;
        while (cnt < n) begin
            @(negedge clk);
            if (result_valid) begin
                cnt++;
                if (flip && cnt == 2) diff_mode = ~dm;
            end
        end
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R12 deselect at end", {31'h0, cs_n}, 32'd1);
        e0 = sclk_rises;
        repeat (300) @(negedge clk);
        chk(sclk_rises == e0, "R12 no clock after end", 32'(sclk_rises), 32'(e0));
        chk(expq.size() == 0, "R9 all results seen", 32'(expq.size()), 32'd0);
        chk(result_valid == 1'b0, "R1 idle strobe", {31'h0, result_valid}, 32'd0);
        diff_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", {31'h0, cs_n}, 32'd1);
        chk(sclk == 1'b0, "R1 reset sclk", {31'h0, sclk}, 32'd0);
        chk(result_valid == 1'b0, "R1 reset valid", {31'h0, result_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // single-ended, wraps past channel 7
        session(1'b0, 10, 1'b0);
        // differential, wraps past pair 3, mode flipped mid-session (ignored)
        session(1'b1, 6, 1'b1);
        // new session: setup again, channel restarts at 0
        session(1'b0, 3, 1'b0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule